// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast clock by N = B·P + A for the feedback path of a phase-locked loop. A synchronous prescaler counts either P or P+1 input cycles per output tick. A swallow counter holds it at P+1 for the first A ticks of each divide period. A main counter ends the period after B ticks. Over one period the prescaler therefore spends A ticks at P+1 and B−A ticks at P, for B·P + A input cycles in total. A companion reference divider, clocked on the same edge, divides by a 14-bit value R. The two pulse trains feed a phase detector.

The configuration is written with a single load strobe that carries A, B, a prescaler-select bit and R. Each write is checked before it is accepted. An accepted write is parked and takes effect only at the next period boundary of the divider it belongs to. A counter-reset request holds both dividers at their starting count. Releasing it starts both from the same cycle.

A parameter picks the band. The low band offers 8/9 and 16/17. The high band offers 64/65 and 32/33.

Top module: `pulse_swallow_div`

## Requirements
- R1: After reset the settings are A=0, B=1, select=0, R=1 and the error flag is 0. The feedback pulse period is the lower modulus of select 0, and the reference pulse occurs every cycle.
- R2: With A=0 the feedback pulse period is B·P input cycles.
- R3: With 0 < A ≤ B the period is B·P + A. A=B is legal.
- R4: The select bit sets P. In the low band, 0 gives 8 and 1 gives 16. In the high band, 0 gives 64 and 1 gives 32.
- R5: The full ranges are usable: B up to 2047 with A up to 63. With B=2047, A=63 and select 0 in the low band, the period is 16439.
- R6: A load with A > B, with B = 0, or with R = 0 is rejected, and it sets the error flag. All settings stay as they were, so the output periods do not change.
- R7: The error flag stays set through later loads and is cleared only by rst_ni.
- R8: The reference pulse period is R input cycles for R from 1 to 16383.
- R9: While cnt_rst_i is high, neither output pulses. After cnt_rst_i is released in cycle c, the first reference pulse comes R cycles after the last held cycle and the first feedback pulse comes N cycles after it. When N = R the two pulses coincide.
- R10: A valid load during a running period does not change that period. The new N applies from the next period onwards.
- R11: fb_pulse_o is high for exactly one input cycle per period.
- R12: A load accepted while cnt_rst_i is high is in force from the first period after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 6 | Swallow count A |
| b_i | input | 11 | Main count B |
| psel_i | input | 1 | Prescaler pair select |
| r_i | input | 14 | Reference divide ratio R |
| load_i | input | 1 | Capture a_i, b_i, psel_i and r_i |
| cnt_rst_i | input | 1 | Hold both dividers at their starting count |
| fb_pulse_o | output | 1 | One-cycle pulse at the end of each N period |
| ref_pulse_o | output | 1 | One-cycle pulse at the end of each R period |
| cfg_err_o | output | 1 | Sticky flag for a rejected load |

## Verification
The main instance is built for the low band (HIGH_BAND=0). Its short moduli keep the 2047/63 maximum period and the 16383 reference period within a short run, and they make the mid-period reload and hold-release alignment cases cheap to repeat. A second instance built with HIGH_BAND=1 covers the 64/65 and 32/33 prescaler pairs through the same ports. A swallow count of 3 and a main count of 5 are used there, so a wrong lower modulus or a missing swallow shows directly in the first period after release.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int A_W = 6;
  localparam int B_W = 11;
  localparam int R_W = 14;
  localparam int P_W = 7;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           psel;
  } fb_cfg_t;

  function automatic logic [P_W-1:0] p_of(input bit high_band, input logic psel);
    if (high_band) return psel ? P_W'(32) : P_W'(64);
    return psel ? P_W'(16) : P_W'(8);
  endfunction
endpackage

// File: rtl/psw_cfg_shadow.sv
module psw_cfg_shadow
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  fb_cfg_t        cfg_i,
  input  logic [R_W-1:0] r_i,
  input  logic           fb_swap_i,
  input  logic           ref_swap_i,
  output fb_cfg_t        fb_nxt_o,
  output fb_cfg_t        fb_act_o,
  output logic [R_W-1:0] r_nxt_o,
  output logic           err_o
);
  fb_cfg_t        fb_pend;
  logic           fb_pv;
  logic [R_W-1:0] r_act, r_pend;
  logic           r_pv;
  logic           bad;

  assign bad      = (cfg_i.b == '0) || (B_W'(cfg_i.a) > cfg_i.b) || (r_i == '0);
  assign fb_nxt_o = fb_pv ? fb_pend : fb_act_o;
  assign r_nxt_o  = r_pv ? r_pend : r_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_act_o <= '{a: '0, b: B_W'(1), psel: 1'b0};
      fb_pend  <= '0;
      fb_pv    <= 1'b0;
      r_act    <= R_W'(1);
      r_pend   <= '0;
      r_pv     <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      if (fb_swap_i) begin
        fb_act_o <= fb_nxt_o;
        fb_pv    <= 1'b0;
      end
      if (ref_swap_i) begin
        r_act <= r_nxt_o;
        r_pv  <= 1'b0;
      end
      if (load_i) begin
        if (bad) begin
          err_o <= 1'b1;
        end else begin
          fb_pend <= cfg_i;
          fb_pv   <= 1'b1;
          r_pend  <= r_i;
          r_pv    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
#(
  parameter int P_RST = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           reload_i,
  input  logic           mod_hi_i,
  input  logic [P_W-1:0] p_i,
  output logic           tick_o
);
  logic [P_W-1:0] pc;

  assign tick_o = (pc == '0) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= P_W'(P_RST - 1);
    end else if (reload_i || tick_o) begin
      // count P+1 cycles when swallowing, P otherwise
      pc <= mod_hi_i ? p_i : p_i - 1'b1;
    end else begin
      pc <= pc - 1'b1;
    end
  end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] a_nxt_i,
  input  logic [B_W-1:0] b_nxt_i,
  output logic           end_o,
  output logic           mod_hi_o
);
  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;
  logic           swap;

  assign end_o    = tick_i && (b_rem == B_W'(1));
  assign swap     = hold_i || end_o;
  assign mod_hi_o = swap ? (a_nxt_i != '0) : (a_rem > A_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rem <= '0;
      b_rem <= B_W'(1);
    end else if (swap) begin
      a_rem <= a_nxt_i;
      b_rem <= b_nxt_i;
    end else if (tick_i) begin
      b_rem <= b_rem - 1'b1;
      if (a_rem != '0) a_rem <= a_rem - 1'b1;
    end
  end
endmodule

// File: rtl/psw_ref_div.sv
module psw_ref_div
  import psw_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic [R_W-1:0] r_nxt_i,
  output logic           pulse_o,
  output logic           swap_o
);
  logic [R_W-1:0] r_cnt;

  assign pulse_o = (r_cnt == '0) && !hold_i;
  assign swap_o  = hold_i || pulse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_cnt <= '0;
    else if (swap_o) r_cnt <= r_nxt_i - 1'b1;
    else             r_cnt <= r_cnt - 1'b1;
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psw_pkg::*;
#(
  parameter bit HIGH_BAND = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           psel_i,
  input  logic [R_W-1:0] r_i,
  input  logic           load_i,
  input  logic           cnt_rst_i,
  output logic           fb_pulse_o,
  output logic           ref_pulse_o,
  output logic           cfg_err_o
);
  localparam int P_RST = int'(p_of(HIGH_BAND, 1'b0));

  fb_cfg_t        cfg_in, fb_nxt, fb_act;
  logic [R_W-1:0] r_nxt;
  logic           fb_end, fb_swap, ref_swap;
  logic           tick, mod_hi;
  logic [P_W-1:0] p_use;

  assign cfg_in     = '{a: a_i, b: b_i, psel: psel_i};
  assign fb_swap    = cnt_rst_i || fb_end;
  assign p_use      = p_of(HIGH_BAND, fb_swap ? fb_nxt.psel : fb_act.psel);
  assign fb_pulse_o = fb_end;

  psw_cfg_shadow u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .cfg_i      (cfg_in),
    .r_i        (r_i),
    .fb_swap_i  (fb_swap),
    .ref_swap_i (ref_swap),
    .fb_nxt_o   (fb_nxt),
    .fb_act_o   (fb_act),
    .r_nxt_o    (r_nxt),
    .err_o      (cfg_err_o)
  );

  psw_prescaler #(.P_RST(P_RST)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (cnt_rst_i),
    .reload_i (fb_swap),
    .mod_hi_i (mod_hi),
    .p_i      (p_use),
    .tick_o   (tick)
  );

  psw_swallow u_swal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (cnt_rst_i),
    .tick_i   (tick),
    .a_nxt_i  (fb_nxt.a),
    .b_nxt_i  (fb_nxt.b),
    .end_o    (fb_end),
    .mod_hi_o (mod_hi)
  );

  psw_ref_div u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (cnt_rst_i),
    .r_nxt_i (r_nxt),
    .pulse_o (ref_pulse_o),
    .swap_o  (ref_swap)
  );
endmodule

// File: rtl/psw_div_chk.sv
module psw_div_chk
  import psw_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [A_W-1:0] a_i,
  input logic [B_W-1:0] b_i,
  input logic [R_W-1:0] r_i,
  input logic           load_i,
  input logic           cnt_rst_i,
  input logic           fb_pulse_o,
  input logic           ref_pulse_o,
  input logic           cfg_err_o
);
  p_one_wide_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  p_hold_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_i |-> (!fb_pulse_o && !ref_pulse_o));

  p_release_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnt_rst_i) |-> !fb_pulse_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  p_bad_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ((b_i == '0) || (B_W'(a_i) > b_i) || (r_i == '0))) |=> cfg_err_o);
endmodule

bind pulse_swallow_div psw_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_i         (a_i),
  .b_i         (b_i),
  .r_i         (r_i),
  .load_i      (load_i),
  .cnt_rst_i   (cnt_rst_i),
  .fb_pulse_o  (fb_pulse_o),
  .ref_pulse_o (ref_pulse_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  a = '0;
  logic [10:0] b = 11'd1;
  logic        sel = 1'b0;
  logic [13:0] r = 14'd1;
  logic        load = 1'b0;
  logic        cnt_rst = 1'b0;
  logic        fb_p, ref_p, err;

  logic [5:0]  h_a = '0;
  logic [10:0] h_b = 11'd1;
  logic        h_sel = 1'b0;
  logic [13:0] h_r = 14'd1;
  logic        h_load = 1'b0;
  logic        h_cnt_rst = 1'b1;
  logic        h_fb, h_ref, h_err;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_fb = 0;
  int last_ref = 0;
  int hold_pulses = 0;
  bit prev_fb = 0;
  bit done = 0;
  int    fb_q[$];
  string fb_tag_q[$];
  int    ref_q[$];
  string ref_tag_q[$];

  always #2.5 clk = ~clk;

  pulse_swallow_div #(.HIGH_BAND(1'b0)) u_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .psel_i(sel), .r_i(r),
    .load_i(load), .cnt_rst_i(cnt_rst),
    .fb_pulse_o(fb_p), .ref_pulse_o(ref_p), .cfg_err_o(err));

  pulse_swallow_div #(.HIGH_BAND(1'b1)) u_pulse_swallow_div_hi (
    .clk_i(clk), .rst_ni(rst_n), .a_i(h_a), .b_i(h_b), .psel_i(h_sel), .r_i(h_r),
    .load_i(h_load), .cnt_rst_i(h_cnt_rst),
    .fb_pulse_o(h_fb), .ref_pulse_o(h_ref), .cfg_err_o(h_err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected intervals as pulses appear
  always @(negedge clk) begin
    int e;
    string t;
    if (!rst_n || cnt_rst) begin
      if (rst_n && (fb_p || ref_p)) hold_pulses++;
      last_fb  = cyc;
      last_ref = cyc;
      prev_fb  = 1'b0;
    end else begin
      if (fb_p) begin
        check(!prev_fb, "R11 fb pulse width", prev_fb ? 2 : 1, 1);
        if (fb_q.size() > 0) begin
          e = fb_q.pop_front();
          t = fb_tag_q.pop_front();
          check((cyc - last_fb) == e, t, cyc - last_fb, e);
        end
        last_fb = cyc;
      end
      prev_fb = fb_p;
      if (ref_p) begin
        if (ref_q.size() > 0) begin
          e = ref_q.pop_front();
          t = ref_tag_q.pop_front();
          check((cyc - last_ref) == e, t, cyc - last_ref, e);
        end
        last_ref = cyc;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic push_fb(input int n, input int times, input string tag);
    for (int i = 0; i < times; i++) begin
      fb_q.push_back(n);
      fb_tag_q.push_back(tag);
    end
  endtask

  task automatic push_ref(input int n, input int times, input string tag);
    for (int i = 0; i < times; i++) begin
      ref_q.push_back(n);
      ref_tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (fb_q.size() != 0 || ref_q.size() != 0) @(negedge clk);
  endtask

  task automatic load_cfg(input int av, input int bv, input bit sv, input int rv);
    @(posedge clk); #1;
    a = 6'(av); b = 11'(bv); sel = sv; r = 14'(rv); load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  task automatic hold_load(input int av, input int bv, input bit sv, input int rv,
                           input int extra);
    @(posedge clk); #1;
    cnt_rst = 1'b1;
    repeat (2) @(posedge clk);
    load_cfg(av, bv, sv, rv);
    repeat (2 + extra) @(posedge clk);
    #1 cnt_rst = 1'b0;
  endtask

  task automatic measure_hi(input int av, input int bv, input bit sv, input int exp,
                            input string tag);
    int n;
    @(posedge clk); #1;
    h_cnt_rst = 1'b1;
    h_a = 6'(av); h_b = 11'(bv); h_sel = sv; h_r = 14'd100; h_load = 1'b1;
    @(posedge clk); #1;
    h_load = 1'b0;
    repeat (2) @(posedge clk);
    #1 h_cnt_rst = 1'b0;
    n = 0;
    while (n < 1000) begin
      @(negedge clk);
      n++;
      if (h_fb) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    push_fb(8, 2, "R1 default fb period");
    push_ref(1, 2, "R1 default ref period");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(err == 1'b0, "R1 err after reset", int'(err), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    drain();

    // R2 / R8 / R9: A=0, B=3, P=8 -> 24, aligned with R=24
    hold_load(0, 3, 1'b0, 24, 0);
    push_fb(24, 2, "R2 B*P period");
    push_ref(24, 2, "R9 ref aligned with fb after release");
    drain();

    // R3: swallow A=5 on B=7, P=8 -> 61
    hold_load(5, 7, 1'b0, 61, 0);
    push_fb(61, 2, "R3 swallow period");
    push_ref(61, 1, "R8 ref period 61");
    drain();

    // R3 / R4: A=B=7 with P=16 -> 119
    hold_load(7, 7, 1'b1, 119, 0);
    push_fb(119, 2, "R4 select 1 gives 16, A=B");
    drain();

    // R5 / R8: full ranges
    hold_load(63, 2047, 1'b0, 16383, 0);
    push_fb(16439, 1, "R5 max A and B");
    push_ref(16383, 1, "R8 max R");
    drain();

    // R10: mid-period load applies from next period
    hold_load(0, 2, 1'b0, 16, 0);
    push_fb(16, 1, "R10 start period");
    drain();
    load_cfg(1, 2, 1'b0, 16);
    push_fb(16, 1, "R10 running period kept");
    push_fb(17, 2, "R10 new period after boundary");
    drain();

    // R6 / R7: rejected loads
    load_cfg(5, 3, 1'b0, 17);
    @(negedge clk);
    check(err == 1'b1, "R6 A>B flags error", int'(err), 1);
    load_cfg(0, 0, 1'b0, 17);
    load_cfg(0, 3, 1'b0, 0);
    push_fb(17, 2, "R6 rejected loads leave period");
    drain();
    load_cfg(1, 2, 1'b0, 17);
    @(negedge clk);
    check(err == 1'b1, "R7 error stays after valid load", int'(err), 1);

    // R9 / R12: long hold with load inside
    hold_pulses = 0;
    hold_load(2, 3, 1'b1, 50, 40);
    check(hold_pulses == 0, "R9 no pulses during hold", hold_pulses, 0);
    push_fb(50, 2, "R12 load during hold in force");
    push_ref(50, 1, "R12 ref from hold load");
    drain();

    // R7 / R1: reset clears error and restores defaults
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check(err == 1'b0, "R7 reset clears error", int'(err), 0);
    push_fb(8, 1, "R1 default after second reset");
    @(posedge clk); #1 rst_n = 1'b1;
    drain();

    // R4 high band instance
    measure_hi(3, 5, 1'b0, 323, "R4 high band select 0 gives 64");
    measure_hi(3, 5, 1'b1, 163, "R4 high band select 1 gives 32");
    @(negedge clk);
    check(h_err == 1'b0, "R1 high band err clear", int'(h_err), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule